// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight device request lines into one interrupt output for a processor. Each line works in one of two trigger modes. In edge mode a rising transition is remembered until it is serviced. In level mode the request simply follows the line, so several devices can share one line with wired-OR and each gets serviced in turn. Fixed priority picks the winner: line 0 is the most urgent and line 7 the least.

The processor answers the interrupt with two acknowledge cycles. On the first cycle the controller commits the winning line to its in-service set. On the second it returns a vector made of a programmable base and the line index. If the request that raised the interrupt has disappeared by the first acknowledge cycle, the controller still answers: it returns the vector of line 7 and marks nothing as in service. A small register port lets the processor do four things: mask lines, pick the trigger mode of each line, set the vector base, and issue a non-specific end-of-interrupt. The same port reads back the request and in-service state.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask, mode, base, request and in-service values all read zero, `cpuIntOut` is low and `vecValid` is low.
- R2: The register port decodes `regAddr` as follows:
  - Address 0 is the mask, read/write; bit i set blocks line i.
  - Address 1 is the mode, read/write; bit i set selects level mode for line i, and bit i clear selects edge mode.
  - Address 2 is the vector base, read/write. Only bits 7:3 are stored, and bits 2:0 read as zero.
  - Address 3 reads the effective request vector. Writes to it are ignored.
  - Address 4 reads the in-service vector. A write to it is the end-of-interrupt command.
  - Addresses 5 to 7 read zero.
- R3: `cpuIntOut` is a combinational function of the current state and inputs. It is high exactly when some unmasked requesting line has a lower index than every in-service line.
- R4: The first cycle with `ackIn` high commits the winning line: it sets that line's in-service bit and clears its edge latch. The next cycle with `ackIn` high emits the vector: in the cycle after it, `vecValid` is high for one cycle and `vecOut` equals {base bits 7:3, line index}.
- R5: If no line would win at the first acknowledge cycle, the vector emitted carries index 7 and the in-service vector is unchanged.
- R6: An end-of-interrupt clears only the lowest-indexed set in-service bit.
- R7: In edge mode, a rising edge sets a request latch that stays set after the line falls. A line that stays high after it has been acknowledged raises no new request until it falls and rises again.
- R8: In level mode, the request equals the line itself. A line that is still high when its end-of-interrupt is written raises `cpuIntOut` again.
- R9: A set mask bit keeps its line from raising `cpuIntOut`. An edge request latched while the line is masked is delivered once the bit is cleared.
- R10: When several lines request at once, the lowest index is served first. A lower-priority request waits while a higher-priority line is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 8 | Device request lines |
| ackIn | input | 1 | Interrupt-acknowledge strobe, one cycle per phase |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| cpuIntOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector from the last acknowledge |
| vecValid | output | 1 | One-cycle pulse marking a fresh vector |

## Verification
The bench covers the following corner cases, each with the failure it would expose:
- A level request that vanishes between the interrupt and the acknowledge. A faulty design would set a stale in-service bit or return a real line's vector instead of line 7.
- An edge line held high through service. A design that sampled levels would interrupt again forever.
- A level line still high at end-of-interrupt. A design that latched edges only would lose the shared device.
- A nested case: a higher-priority line interrupts while a lower one is in service. An end-of-interrupt that cleared the wrong bit would unblock the wrong line.
- Masking and unmasking around a latched edge, to prove the request is kept rather than dropped.

Random traffic on every input is checked against a bench model cycle by cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_REQ  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 3'd4;

  typedef struct packed {
    logic ackCapture;  // first acknowledge cycle
    logic ackEmit;     // second acknowledge cycle
    logic eoiCmd;      // non-specific end of interrupt
    logic wrMask;
    logic wrMode;
    logic wrBase;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vecIn,
  output logic          hitOut,
  output logic [IW-1:0] idxOut
);

  // Lowest set index wins; scanning downward leaves the lowest one last.
  always_comb begin
    idxOut = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vecIn[i]) idxOut = IW'(i);
    end
  end

  assign hitOut = |vecIn;

endmodule

// File: rtl/irq_prio_ctrl_fsm.sv
module irq_prio_ctrl_fsm
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        strobes
);

  logic phaseQ;  // 0: next acknowledge captures, 1: next acknowledge emits

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
    end else if (ackIn) begin
      phaseQ <= ~phaseQ;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.ackCapture = ackIn & ~phaseQ;
    strobes.ackEmit    = ackIn & phaseQ;
    strobes.eoiCmd     = regWrEn && (regAddr == ADDR_SVC);
    strobes.wrMask     = regWrEn && (regAddr == ADDR_MASK);
    strobes.wrMode     = regWrEn && (regAddr == ADDR_MODE);
    strobes.wrBase     = regWrEn && (regAddr == ADDR_BASE);
  end

endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = $clog2(LINES),
  parameter int BASE_W = LINES - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  ctlStrobe_t        strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LINES-1:0]  regWrData,
  output logic [LINES-1:0]  regRdData,
  output logic              intOut,
  output logic [LINES-1:0]  vecOut,
  output logic              vecValid,
  output logic [LINES-1:0]  maskView,
  output logic [LINES-1:0]  reqView,
  output logic [LINES-1:0]  svcView
);

  logic [LINES-1:0]  maskQ, modeQ, prevQ, latchQ, svcQ;
  logic [BASE_W-1:0] baseQ;
  logic [IDX_W-1:0]  holdIdxQ;
  logic [LINES-1:0]  vecQ;
  logic              vecValidQ;

  logic [LINES-1:0]  reqVec, pendVec, winBit, svcLow, capSet, eoiClr;
  logic              pendHit, svcHit, winner;
  logic [IDX_W-1:0]  pendIdx, svcIdx;

  // Per-line request source: level lines pass through, edge lines use a latch.
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchQ[g] <= 1'b0;
        prevQ[g]  <= 1'b0;
      end else begin
        prevQ[g] <= lineIn[g];
        if (lineIn[g] && !prevQ[g] && !modeQ[g]) latchQ[g] <= 1'b1;
        else if (capSet[g])                      latchQ[g] <= 1'b0;
      end
    end
    assign reqVec[g] = modeQ[g] ? lineIn[g] : latchQ[g];
  end

  assign pendVec = reqVec & ~maskQ;

  irq_prio_enc #(.N(LINES), .IW(IDX_W)) u_pendEnc (
    .vecIn (pendVec),
    .hitOut(pendHit),
    .idxOut(pendIdx)
  );

  irq_prio_enc #(.N(LINES), .IW(IDX_W)) u_svcEnc (
    .vecIn (svcQ),
    .hitOut(svcHit),
    .idxOut(svcIdx)
  );

  assign winner = pendHit && (!svcHit || (pendIdx < svcIdx));
  assign intOut = winner;

  assign winBit = winner ? (LINES'(1) << pendIdx) : '0;
  assign svcLow = svcHit ? (LINES'(1) << svcIdx) : '0;
  assign capSet = strobes.ackCapture ? winBit : '0;
  assign eoiClr = strobes.eoiCmd ? svcLow : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcQ      <= '0;
      maskQ     <= '0;
      modeQ     <= '0;
      baseQ     <= '0;
      holdIdxQ  <= '0;
      vecQ      <= '0;
      vecValidQ <= 1'b0;
    end else begin
      svcQ <= (svcQ & ~eoiClr) | capSet;
      if (strobes.wrMask) maskQ <= regWrData;
      if (strobes.wrMode) modeQ <= regWrData;
      if (strobes.wrBase) baseQ <= regWrData[LINES-1:IDX_W];
      if (strobes.ackCapture) holdIdxQ <= winner ? pendIdx : IDX_W'(LINES - 1);
      if (strobes.ackEmit) vecQ <= {baseQ, holdIdxQ};
      vecValidQ <= strobes.ackEmit;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_MASK: regRdData = maskQ;
      ADDR_MODE: regRdData = modeQ;
      ADDR_BASE: regRdData = {baseQ, {IDX_W{1'b0}}};
      ADDR_REQ:  regRdData = reqVec;
      ADDR_SVC:  regRdData = svcQ;
      default:   regRdData = '0;
    endcase
  end

  assign vecOut   = vecQ;
  assign vecValid = vecValidQ;
  assign maskView = maskQ;
  assign reqView  = reqVec;
  assign svcView  = svcQ;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic              ackIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LINES-1:0]  regWrData,
  output logic [LINES-1:0]  regRdData,
  output logic              cpuIntOut,
  output logic [LINES-1:0]  vecOut,
  output logic              vecValid
);

  ctlStrobe_t       strobes;
  logic [LINES-1:0] maskView, reqView, svcView;

  irq_prio_ctrl_fsm u_fsm (
    .clk    (clk),
    .rstN   (rstN),
    .ackIn  (ackIn),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  irq_prio_dp #(.LINES(LINES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .intOut   (cpuIntOut),
    .vecOut   (vecOut),
    .vecValid (vecValid),
    .maskView (maskView),
    .reqView  (reqView),
    .svcView  (svcView)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackIn,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic             cpuIntOut,
  input logic             vecValid,
  input logic             captureStb,
  input logic [LINES-1:0] maskView,
  input logic [LINES-1:0] reqView,
  input logic [LINES-1:0] svcView
);

  logic eoiWr;
  assign eoiWr = regWrEn && (regAddr == 3'd4);

  p_int_needs_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuIntOut |-> ((reqView & ~maskView) != '0));

  p_vec_after_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackIn));

  p_vec_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  p_capture_adds_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> ($countones(svcView) <= $countones($past(svcView)) + 1));

  p_spurious_keeps_svc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (captureStb && !cpuIntOut && !eoiWr) |=> $stable(svcView));

  p_eoi_drops_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && !ackIn && (svcView != '0)) |=>
      ($countones(svcView) == $countones($past(svcView)) - 1));

  p_full_mask_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskView == '1) |-> !cpuIntOut);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ackIn     (ackIn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .cpuIntOut (cpuIntOut),
  .vecValid  (vecValid),
  .captureStb(strobes.ackCapture),
  .maskView  (maskView),
  .reqView   (reqView),
  .svcView   (svcView)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic [7:0] lineIn;
  logic       ackIn, regWrEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData, vecOut;
  logic       cpuIntOut, vecValid;

  irq_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .ackIn(ackIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuIntOut(cpuIntOut), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] mMask, mMode, mLatch, mPrev, mSvc, mVec;
  logic [4:0] mBase;
  logic [2:0] mHold;
  logic       mPhase, mVecValid;

  logic [7:0] lv;
  logic [2:0] rdA;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowIdx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] mReq();
    return (mMode & lineIn) | (~mMode & mLatch);
  endfunction

  function automatic bit mWin(output int p);
    int s;
    p = lowIdx(mReq() & ~mMask);
    s = lowIdx(mSvc);
    return (p < 8) && (p < s);
  endfunction

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mMask;
      3'd1: return mMode;
      3'd2: return {mBase, 3'b000};
      3'd3: return mReq();
      3'd4: return mSvc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelUpdate();
    int p, s;
    bit win;
    logic [7:0] capSet, eoiClr, newEdge;
    win = mWin(p);
    newEdge = lineIn & ~mPrev & ~mMode;
    capSet = 8'h00;
    eoiClr = 8'h00;
    mVecValid = ackIn && mPhase;
    if (ackIn && mPhase) mVec = {mBase, mHold};
    if (ackIn && !mPhase) begin
      if (win) capSet = 8'h01 << p;
      mHold = win ? 3'(p) : 3'd7;
    end
    if (regWrEn && regAddr == 3'd4) begin
      s = lowIdx(mSvc);
      if (s < 8) eoiClr = 8'h01 << s;
    end
    if (ackIn) mPhase = ~mPhase;
    mSvc   = (mSvc & ~eoiClr) | capSet;
    mLatch = (mLatch & ~capSet) | newEdge;
    if (regWrEn && regAddr == 3'd0) mMask = regWrData;
    if (regWrEn && regAddr == 3'd1) mMode = regWrData;
    if (regWrEn && regAddr == 3'd2) mBase = regWrData[7:3];
    mPrev = lineIn;
  endtask

  task automatic step(input logic [7:0] lines, input bit ack, input bit wr,
                      input logic [2:0] addr, input logic [7:0] data);
    int p;
    bit win;
    @(negedge clk);
    lineIn = lines; ackIn = ack; regWrEn = wr; regAddr = addr; regWrData = data;
    #1;
    win = mWin(p);
    chk("R3 cpuIntOut", {7'd0, cpuIntOut}, {7'd0, win});
    chk("R2 readback", regRdData, mRead(addr));
    chk("R4 vecValid", {7'd0, vecValid}, {7'd0, mVecValid});
    if (mVecValid) chk("R4 vecOut", vecOut, mVec);
    @(posedge clk);
    #1;
    modelUpdate();
  endtask

  task automatic idle();                               step(lv, 0, 0, rdA, 8'h00); endtask
  task automatic wrReg(input logic [2:0] a, input logic [7:0] d); step(lv, 0, 1, a, d); endtask
  task automatic ackPair(); step(lv, 1, 0, rdA, 8'h00); step(lv, 1, 0, rdA, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; lineIn = 0; ackIn = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    mMask = 0; mMode = 0; mLatch = 0; mPrev = 0; mSvc = 0; mVec = 0;
    mBase = 0; mHold = 0; mPhase = 0; mVecValid = 0;
    lv = 0; rdA = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      step(8'h00, 0, 0, 3'(a), 8'h00);
      chk("R1 reset register", regRdData, 8'h00);
    end
    chk("R1 reset int", {7'd0, cpuIntOut}, 8'h00);
    chk("R1 reset vecValid", {7'd0, vecValid}, 8'h00);

    // R2: base keeps only upper bits, request address ignores writes
    wrReg(3'd2, 8'h47);
    rdA = 3'd2; idle();
    chk("R2 base low bits", regRdData, 8'h40);
    wrReg(3'd3, 8'hFF);
    rdA = 3'd3; idle();
    chk("R2 request write ignored", regRdData, 8'h00);
    wrReg(3'd1, 8'h20);  // line 5 level, others edge
    rdA = 3'd0;

    // R7: edge latch holds after the line falls
    lv = 8'h04; idle();
    chk("R7 edge raises int", {7'd0, cpuIntOut}, 8'h01);
    lv = 8'h00; idle();
    chk("R7 latch holds", {7'd0, cpuIntOut}, 8'h01);
    ackPair();
    chk("R4 vector line2", vecOut, 8'h42);
    chk("R4 vector pulse", {7'd0, vecValid}, 8'h01);
    // R7: line held high after acknowledge does not retrigger
    lv = 8'h01; idle();
    ackPair();
    chk("R7 vector line0", vecOut, 8'h40);
    wrReg(3'd4, 8'h00);
    chk("R7 held-high no retrigger", {7'd0, cpuIntOut}, 8'h00);
    wrReg(3'd4, 8'h00);
    lv = 8'h00; idle();

    // R8: level line re-raised after end-of-interrupt
    lv = 8'h20; idle();
    chk("R8 level raises int", {7'd0, cpuIntOut}, 8'h01);
    ackPair();
    chk("R8 vector line5", vecOut, 8'h45);
    chk("R3 blocked by own service", {7'd0, cpuIntOut}, 8'h00);
    wrReg(3'd4, 8'h00);
    chk("R8 re-raise after eoi", {7'd0, cpuIntOut}, 8'h01);

    // R5: request vanishes before acknowledge
    lv = 8'h00; idle();
    ackPair();
    chk("R5 spurious vector", vecOut, 8'h47);
    rdA = 3'd4; idle();
    chk("R5 no in-service bit", regRdData, 8'h00);
    rdA = 3'd0;

    // R9: mask holds an edge request until cleared
    wrReg(3'd0, 8'h08);
    lv = 8'h08; idle();
    lv = 8'h00; idle();
    chk("R9 masked silent", {7'd0, cpuIntOut}, 8'h00);
    wrReg(3'd0, 8'h00);
    chk("R9 delivered on unmask", {7'd0, cpuIntOut}, 8'h01);
    ackPair();
    chk("R9 vector line3", vecOut, 8'h43);
    wrReg(3'd4, 8'h00);

    // R10: fixed priority and nesting block
    lv = 8'h12; idle();
    lv = 8'h00;
    ackPair();
    chk("R10 lowest index first", vecOut, 8'h41);
    chk("R10 lower waits", {7'd0, cpuIntOut}, 8'h00);
    wrReg(3'd4, 8'h00);
    chk("R10 lower released", {7'd0, cpuIntOut}, 8'h01);
    ackPair();
    chk("R10 second vector", vecOut, 8'h44);
    wrReg(3'd4, 8'h00);

    // R6: end-of-interrupt clears only the lowest in-service bit
    lv = 8'h40; idle();
    lv = 8'h00; ackPair();
    lv = 8'h04; idle();
    lv = 8'h00; ackPair();
    rdA = 3'd4; idle();
    chk("R6 nested in-service", regRdData, 8'h44);
    wrReg(3'd4, 8'h00);
    chk("R6 eoi clears lowest", regRdData, 8'h40);
    wrReg(3'd4, 8'h00);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      bit ak, wr;
      logic [2:0] a;
      if ($urandom % 4 == 0) lv = 8'($urandom);
      ak = ($urandom % 5 == 0);
      wr = ($urandom % 6 == 0);
      a  = 3'($urandom % 6);
      d  = 8'($urandom);
      if (wr && a == 3'd0) d = d & 8'($urandom);
      step(lv, ak, wr, a, d);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule